// File: doc/BRIEF.md
# Time-Shared Wavelet Analysis Filter Pair

This block performs a single level of discrete wavelet analysis on a stream of signed samples. A scaling (low-pass) filter and a wavelet (high-pass) filter, each 20 taps long and derived from the orthogonal wavelet with ten vanishing moments, run side by side. Each filter owns one multiplier and one accumulator, and it walks through its taps one per clock. Both filters read the same 20-deep window of recent samples.

Samples arrive with a one-cycle strobe at a rate at least 21 times slower than the clock. Each accepted sample starts a 20-cycle multiply-accumulate pass. The result is scaled back by 2^10 and kept only for every second sample, which gives the down-sampled approximation and detail sequences. Both sequences are marked by one shared valid pulse.

Top module: `wv_analysis_pair`

## Requirements
- R1: While reset is high, and on the first cycle after it, `out_vld` is 0 and `approx` and `detail` are 0.
- R2: For input sequence x[n] (x[n] newest), a retained `approx` equals floor((sum over i=0..19 of h[i]*x[n-i]) / 1024). h[i] is the scaling filter of the ten-vanishing-moment orthogonal wavelet, multiplied by 1024 and rounded to the nearest integer (h[0]=27, h[3]=705, h[17..19]=0, sum 1447), held as 11-bit two's complement.
- R3: A retained `detail` equals floor((sum over k of g[k]*x[n-k]) / 1024) with g[k] = (-1)^k * h[19-k], so g[3]=1 and g[19]=-27.
- R4: Every result depends only on the 20 most recent accepted samples. A sample stops contributing once 20 newer samples have been accepted.
- R5: Counting accepted samples from 1 after reset, a result is retained exactly when the count is even and at least 20. Each retained result raises `out_vld` for one cycle, and `approx` and `detail` change together only then. They hold their values at every other time.
- R6: When `smp_vld` is sampled high on a rising edge, the retained result for that sample appears on the 20th rising edge after it.
- R7: Full-scale inputs (constant +32767, constant -32768, and alternating extremes) give exact results with no wrap-around.
- R8: `smp_vld` is accepted when it arrives 21 or more cycles after the previous accepted strobe. A closer strobe is outside the input contract.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Filter clock, one tap per cycle |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | One-cycle strobe for a new sample |
| smp_dat | input | DW (16) | Signed input sample |
| out_vld | output | 1 | Pulse marking a retained down-sampled result |
| approx | output | OW (22) | Signed approximation (low-pass) coefficient |
| detail | output | OW (22) | Signed detail (high-pass) coefficient |

## Verification
The assertions assume that the input strobe never arrives while a multiply-accumulate pass is still in progress. The pulse, hold and end-of-pass properties are only meaningful when that holds. The stimulus drives every sample exactly 21 cycles after the previous one, which is the tightest spacing the contract allows, and it never raises the strobe sooner. Data values range over impulses, full-scale constants, alternating extremes and a pseudo-random sweep, so the accumulator sees its largest magnitudes of both signs.

// File: rtl/wv_pkg.sv
package wv_pkg;

    localparam int TAPS      = 20;
    localparam int TAP_IW    = $clog2(TAPS);
    localparam int CNT_W     = $clog2(TAPS + 1);
    localparam int COEF_W    = 11;
    localparam int COEF_FRAC = 10;

    typedef logic signed [COEF_W-1:0] coef_t;

    typedef enum logic {
        SEQ_IDLE,
        SEQ_RUN
    } seq_state_e;

    typedef struct packed {
        logic              run;
        logic              clr;
        logic              last;
        logic              keep;
        logic              warm;
        logic [TAP_IW-1:0] idx;
    } mac_ctl_t;

    // Scaling filter, scaled by 2^COEF_FRAC and rounded (index = tap delay).
    function automatic coef_t lo_coef(input logic [TAP_IW-1:0] k);
        case (k)
            5'd0:    return 11'sd27;
            5'd1:    return 11'sd193;
            5'd2:    return 11'sd540;
            5'd3:    return 11'sd705;
            5'd4:    return 11'sd288;
            5'd5:    return -11'sd256;
            5'd6:    return -11'sd201;
            5'd7:    return 11'sd130;
            5'd8:    return 11'sd95;
            5'd9:    return -11'sd73;
            5'd10:   return -11'sd30;
            5'd11:   return 11'sd34;
            5'd12:   return 11'sd4;
            5'd13:   return -11'sd11;
            5'd14:   return 11'sd1;
            5'd15:   return 11'sd2;
            5'd16:   return -11'sd1;
            default: return '0;
        endcase
    endfunction

    // Wavelet filter: alternating-sign mirror of the scaling filter.
    function automatic coef_t hi_coef(input logic [TAP_IW-1:0] k);
        logic [TAP_IW-1:0] m;
        m = TAP_IW'(TAPS - 1) - k;
        return k[0] ? coef_t'(-lo_coef(m)) : lo_coef(m);
    endfunction

endpackage

// File: rtl/wv_seq.sv
module wv_seq
    import wv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     strobe_i,
    output mac_ctl_t ctl_o
);

    seq_state_e        st_q;
    logic [TAP_IW-1:0] idx_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_nx;
    logic              odd_q;
    logic              keep_q;
    logic              accept;
    logic              at_last;

    assign accept  = strobe_i && (st_q == SEQ_IDLE);
    assign at_last = (st_q == SEQ_RUN) && (idx_q == TAP_IW'(TAPS - 1));
    assign cnt_nx  = (cnt_q == CNT_W'(TAPS)) ? cnt_q : cnt_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SEQ_IDLE;
            idx_q  <= '0;
            cnt_q  <= '0;
            odd_q  <= 1'b0;
            keep_q <= 1'b0;
        end else if (accept) begin
            st_q   <= SEQ_RUN;
            idx_q  <= '0;
            cnt_q  <= cnt_nx;
            odd_q  <= ~odd_q;
            // previous count odd -> this sample's count is even
            keep_q <= (cnt_nx == CNT_W'(TAPS)) && odd_q;
        end else if (st_q == SEQ_RUN) begin
            idx_q <= idx_q + 1'b1;
            if (at_last) begin
                st_q <= SEQ_IDLE;
            end
        end
    end

    always_comb begin
        ctl_o.run  = (st_q == SEQ_RUN);
        ctl_o.clr  = accept;
        ctl_o.last = at_last;
        ctl_o.keep = keep_q;
        ctl_o.warm = (cnt_q == CNT_W'(TAPS));
        ctl_o.idx  = idx_q;
    end

endmodule

// File: rtl/wv_window.sv
module wv_window
    import wv_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    push_i,
    input  logic signed [DW-1:0]    din_i,
    input  logic [TAP_IW-1:0]       sel_i,
    output logic signed [DW-1:0]    tap_o
);

    logic signed [DW-1:0] win_q [TAPS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TAPS; i++) begin
                win_q[i] <= '0;
            end
        end else if (push_i) begin
            for (int i = TAPS - 1; i > 0; i--) begin
                win_q[i] <= win_q[i-1];
            end
            win_q[0] <= din_i;
        end
    end

    assign tap_o = (sel_i < TAP_IW'(TAPS)) ? win_q[sel_i] : '0;

endmodule

// File: rtl/wv_mac.sv
module wv_mac
    import wv_pkg::*;
#(
    parameter int DW   = 16,
    parameter int AW   = 32,
    parameter int OW   = 22,
    parameter int HIGH = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  mac_ctl_t             ctl_i,
    input  logic signed [DW-1:0] smp_i,
    output logic signed [OW-1:0] res_o
);

    localparam int PW = DW + COEF_W;

    coef_t                coef;
    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] acc_q;
    logic signed [AW-1:0] acc_nx;

    generate
        if (HIGH != 0) begin : g_high
            assign coef = hi_coef(ctl_i.idx);
        end else begin : g_low
            assign coef = lo_coef(ctl_i.idx);
        end
    endgenerate

    assign prod   = smp_i * coef;
    assign acc_nx = acc_q + {{(AW-PW){prod[PW-1]}}, prod};
    assign res_o  = OW'(acc_nx >>> COEF_FRAC);

    always_ff @(posedge clk) begin
        if (rst || ctl_i.clr) begin
            acc_q <= '0;
        end else if (ctl_i.run) begin
            acc_q <= acc_nx;
        end
    end

endmodule

// File: rtl/wv_analysis_pair.sv
module wv_analysis_pair
    import wv_pkg::*;
#(
    parameter int  DW    = 16,
    parameter int  GUARD = 5,
    localparam int AW    = DW + COEF_W + GUARD,
    localparam int OW    = AW - COEF_FRAC
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_vld,
    input  logic signed [DW-1:0] smp_dat,
    output logic                 out_vld,
    output logic signed [OW-1:0] approx,
    output logic signed [OW-1:0] detail
);

    mac_ctl_t             ctl;
    logic signed [DW-1:0] tap;
    logic signed [OW-1:0] res [2];
    logic                 emit;

    wv_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .strobe_i (smp_vld),
        .ctl_o    (ctl)
    );

    wv_window #(.DW(DW)) u_win (
        .clk    (clk),
        .rst    (rst),
        .push_i (ctl.clr),
        .din_i  (smp_dat),
        .sel_i  (ctl.idx),
        .tap_o  (tap)
    );

    generate
        for (genvar f = 0; f < 2; f++) begin : g_filt
            wv_mac #(.DW(DW), .AW(AW), .OW(OW), .HIGH(f)) u_mac (
                .clk   (clk),
                .rst   (rst),
                .ctl_i (ctl),
                .smp_i (tap),
                .res_o (res[f])
            );
        end
    endgenerate

    assign emit = ctl.run && ctl.last && ctl.keep;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            approx  <= '0;
            detail  <= '0;
        end else begin
            out_vld <= emit;
            if (emit) begin
                approx <= res[0];
                detail <= res[1];
            end
        end
    end

endmodule

// File: rtl/wv_analysis_chk.sv
module wv_analysis_chk #(
    parameter int OW = 22
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 smp_vld,
    input logic                 busy,
    input logic                 warm,
    input logic                 out_vld,
    input logic signed [OW-1:0] approx,
    input logic signed [OW-1:0] detail
);

    // R8: input contract, no strobe while a pass is running
    a_r8_strobe_gap: assert property (@(posedge clk) disable iff (rst)
        smp_vld |-> !busy);

    // R5: valid is a single-cycle pulse
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        out_vld |=> !out_vld);

    // R5: outputs hold between retained results
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        !out_vld |-> ($stable(approx) && $stable(detail)));

    // R5: nothing is retained before the window has filled
    a_r5_warm: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> warm);

    // R6: a result appears right as the pass ends
    a_r6_end_of_pass: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> ($past(busy) && !busy));

endmodule

bind wv_analysis_pair wv_analysis_chk #(.OW(OW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .smp_vld (smp_vld),
    .busy    (ctl.run),
    .warm    (ctl.warm),
    .out_vld (out_vld),
    .approx  (approx),
    .detail  (detail)
);

// File: tb/sim_wv_analysis_pair.sv
`timescale 1ns/1ps
module sim_wv_analysis_pair;

    localparam int DW   = 16;
    localparam int OW   = 22;
    localparam int TAPS = 20;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 smp_vld = 1'b0;
    logic signed [DW-1:0] smp_dat = '0;
    logic                 out_vld;
    logic signed [OW-1:0] approx;
    logic signed [OW-1:0] detail;

    always #4 clk = ~clk;

    wv_analysis_pair u0 (
        .clk     (clk),
        .rst     (rst),
        .smp_vld (smp_vld),
        .smp_dat (smp_dat),
        .out_vld (out_vld),
        .approx  (approx),
        .detail  (detail)
    );

    int     errors = 0;
    int     checks = 0;
    real    lo_r [TAPS];
    int     h [TAPS];
    int     g [TAPS];
    int     win [TAPS];
    int     cnt;
    longint last_a;
    longint last_d;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        smp_vld = 1'b0;
        repeat (3) @(negedge clk);
        check(out_vld == 1'b0, "R1 out_vld in reset", longint'(out_vld), 0);
        check(approx == '0 && detail == '0, "R1 outputs in reset", longint'(approx), 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_vld == 1'b0 && approx == '0 && detail == '0, "R1 first cycle after reset",
              longint'(detail), 0);
        for (int i = 0; i < TAPS; i++) win[i] = 0;
        cnt = 0;
        last_a = 0;
        last_d = 0;
    endtask

    task automatic push(input int v, input string note);
        longint ea, ed;
        longint ca, cd;
        int     nv, at;
        bit     keep;
        for (int i = TAPS - 1; i > 0; i--) win[i] = win[i-1];
        win[0] = v;
        cnt++;
        keep = (cnt >= TAPS) && (cnt % 2 == 0);
        ea = 0;
        ed = 0;
        for (int i = 0; i < TAPS; i++) begin
            ea += longint'(h[i]) * longint'(win[i]);
            ed += longint'(g[i]) * longint'(win[i]);
        end
        ea = ea >>> 10;
        ed = ed >>> 10;
        smp_vld = 1'b1;
        smp_dat = DW'(v);
        nv = 0; at = 0; ca = 0; cd = 0;
        for (int k = 1; k <= TAPS + 1; k++) begin
            @(negedge clk);
            if (k == 1) smp_vld = 1'b0;
            if (out_vld) begin
                nv++;
                at = k;
                ca = longint'(approx);
                cd = longint'(detail);
            end
        end
        if (keep) begin
            check(nv == 1 && at == TAPS + 1, "R6 R8 result timing", longint'(at), TAPS + 1);
            check(ca == ea, {"R2 approx ", note}, ca, ea);
            check(cd == ed, {"R3 detail ", note}, cd, ed);
            last_a = ea;
            last_d = ed;
        end else begin
            check(nv == 0, "R5 no pulse on dropped sample", longint'(nv), 0);
            check(longint'(approx) == last_a && longint'(detail) == last_d,
                  "R5 outputs hold", longint'(approx), last_a);
        end
    endtask

    function automatic int next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return int'($signed(lfsr));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        lo_r = '{0.026670057900950818, 0.18817680007762133, 0.5272011889309198,
                 0.6884590394525921, 0.2811723436604265, -0.24984642432648865,
                 -0.19594627437659665, 0.12736934033574265, 0.09305736460380659,
                 -0.07139414716586077, -0.02945753682194567, 0.03321267405893324,
                 0.0036065535669883944, -0.010733175482979604, 0.0013953517469940798,
                 0.001992405295185056, -0.0006858566950046825, -0.0001164668549943862,
                 0.00009358867000108985, -0.00001326420300235487};
        for (int i = 0; i < TAPS; i++)
            h[i] = $rtoi(lo_r[i] * 1024.0 + ((lo_r[i] >= 0.0) ? 0.5 : -0.5));
        for (int k = 0; k < TAPS; k++)
            g[k] = ((k % 2 == 0) ? 1 : -1) * h[TAPS - 1 - k];

        // impulse after warm-up, even position (R4: drops out after 20)
        do_reset();
        for (int n = 1; n <= 60; n++) push((n == 22) ? 1024 : 0, "R4 impulse even");
        // impulse at odd position
        do_reset();
        for (int n = 1; n <= 60; n++) push((n == 25) ? -1024 : 0, "R4 impulse odd");
        // full-scale constants and alternation
        do_reset();
        for (int n = 1; n <= 44; n++) push(32767, "R7 const max");
        do_reset();
        for (int n = 1; n <= 44; n++) push(-32768, "R7 const min");
        do_reset();
        for (int n = 1; n <= 50; n++) push((n % 2 == 0) ? 32767 : -32768, "R7 alternating");
        do_reset();
        for (int n = 1; n <= 50; n++) push((n % 2 == 0) ? -32768 : 32767, "R7 alternating swapped");
        // ramp
        do_reset();
        for (int n = 1; n <= 50; n++) push(n * 600 - 15000, "ramp");
        // pseudo-random with a mid-stream reset
        do_reset();
        for (int n = 1; n <= 30; n++) push(next_rand(), "random pre-reset");
        do_reset();
        for (int n = 1; n <= 120; n++) push(next_rand(), "random");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule